// File: doc/BRIEF.md
# Fully Associative Address-Space-Tagged Translation Buffer

This block is a small, fully associative translation buffer. Each entry maps a pair of adjacent virtual pages onto two physical frames: an even frame and an odd frame. Every entry carries its own page mask, an address-space tag and a global flag. A lookup compares the incoming page number with all entries in parallel. The match ignores the bits that the entry's mask marks as don't-care. The result is registered one cycle after the request and gives:
- a hit flag,
- the index of the matching entry,
- the frame, cache attribute and dirty bit of the selected half,
- a flag marking addresses in the uncacheable virtual segment.

Software loads entries through an indexed write port and reads them back in packed form through a read port. A flush input empties the whole buffer. A round-robin fill pointer suggests the next entry to replace, and it advances only when asked. Page-table walking, fault generation and caching belong to the surrounding logic.

Top module: `tlbx`

## Requirements
- R1: An entry takes part in a lookup only when at least one of its halves is valid. It matches when the stored 19-bit pair number equals bits 31:13 of the lookup address on every bit that is 0 in the entry's mask.
- R2: A match also requires the entry's global flag to be set, or its 8-bit address-space tag to equal `lk_asid`.
- R3: The half is chosen by the page-number bit (page number = `lk_vaddr[31:12]`) at position k, where k is the number of ones in the mask. The mask is written as k contiguous low ones. A 1 selects the odd half and a 0 selects the even half.
- R4: When several entries match, the lowest-numbered one is reported. `lk_index` is one bit wider than the entry index and carries that number zero-extended.
- R5: When no entry matches, `lk_index` is all ones, `lk_hit` and `lk_invalid` are 0, and the frame, attribute and dirty outputs are 0.
- R6: When an entry matches but its selected half is not valid, `lk_hit` is 0, `lk_invalid` is 1, `lk_index` gives the entry, and the frame outputs are 0.
- R7: A lookup sampled at a clock edge shows its result after that edge, with `lk_done` high for that one cycle. On a hit, the outputs give the selected half's frame, attribute and dirty bit.
- R8: A write whose `wr_index` is greater than or equal to the entry count is ignored. Every entry keeps its contents.
- R9: Readback packs the entry as follows. The pair word is the pair number shifted left by 13, ORed with the tag. Each half word is frame<<6 | attribute<<3 | dirty<<2 | valid<<1 | global. Write half words use the same layout, with bit 0 ignored.
- R10: Flush zeroes every entry and sets the fill pointer to 0. It takes priority over a write and over an advance in the same cycle.
- R11: `fill_adv` moves the fill pointer up by one and wraps from the last entry to 0. Without `fill_adv`, the pointer holds.
- R12: `lk_uncached` is 1 exactly when bits 31 and 29 of the looked-up address are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space tag |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Matched and selected half valid |
| lk_invalid | output | 1 | Matched but selected half not valid |
| lk_index | output | 4 | Matching index, all ones on no match |
| lk_pfn | output | 20 | Physical frame of the selected half |
| lk_cattr | output | 3 | Cache attribute of the selected half |
| lk_dirty | output | 1 | Dirty bit of the selected half |
| lk_uncached | output | 1 | Address is in the uncacheable segment |
| wr_en | input | 1 | Entry write strobe |
| wr_index | input | 4 | Entry to write |
| wr_mask | input | 19 | Page mask |
| wr_vpn2 | input | 19 | Virtual pair number |
| wr_asid | input | 8 | Address-space tag |
| wr_global | input | 1 | Global flag |
| wr_even_word | input | 26 | Even half, packed |
| wr_odd_word | input | 26 | Odd half, packed |
| flush | input | 1 | Clear all entries |
| fill_adv | input | 1 | Advance fill pointer |
| fill_idx | output | 3 | Suggested entry to fill |
| rd_index | input | 3 | Entry to read back |
| rd_mask | output | 19 | Mask of read entry |
| rd_vpn_word | output | 32 | Packed pair number and tag |
| rd_even_word | output | 26 | Packed even half |
| rd_odd_word | output | 26 | Packed odd half |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Masked compare.** It writes an entry with a four-bit mask and looks up addresses that differ only inside the masked field. A compare that ignores the mask would miss here. A lookup that differs just above the mask must miss, and a mask applied too widely would hit instead.
- **Half select.** The even/odd choice is tested both with and without a mask. A select bit taken from a fixed position would return the wrong frame.
- **Overlaps and invalid halves.** Two entries with the same tag check that the lowest index wins. A half with its valid bit clear must raise the invalid flag, not a hit.
- **Write and flush boundaries.** Writes at the entry count and above must change nothing. A flush in the same cycle as a write must leave the buffer empty.
- **Fill pointer.** The pointer must wrap after the last entry and hold while idle.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PN_W       = VA_W - PAGE_SHIFT;
    localparam int VPN2_W     = PN_W - 1;
    localparam int PFN_W      = 20;
    localparam int ASID_W     = 8;
    localparam int CATTR_W    = 3;
    localparam int HALF_W     = PFN_W + CATTR_W + 3;
    localparam int GAP_W      = VA_W - VPN2_W - ASID_W;

    localparam logic [VA_W-1:0] UNCACHED_SEG = 32'hA000_0000;

    typedef struct packed {
        logic [PFN_W-1:0]   pfn;
        logic [CATTR_W-1:0] cattr;
        logic               dirty;
        logic               valid;
    } half_t;

    typedef struct packed {
        logic [VPN2_W-1:0] mask;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              global_f;
        half_t             even;
        half_t             odd;
    } entry_t;
endpackage

// File: rtl/tlbx_match.sv
module tlbx_match
    import tlbx_pkg::*;
(
    input  entry_t            ent,
    input  logic [PN_W-1:0]   pn,
    input  logic [ASID_W-1:0] asid,
    output logic              match,
    output logic              odd_sel
);
    logic            live;
    logic            tag_ok;
    logic            asid_ok;
    logic [PN_W-1:0] mask_x;
    logic [PN_W-1:0] sel_onehot;

    always_comb begin
        live       = ent.even.valid | ent.odd.valid;
        tag_ok     = ((pn[PN_W-1:1] ^ ent.vpn2) & ~ent.mask) == '0;
        asid_ok    = ent.global_f | (asid == ent.asid);
        match      = live & tag_ok & asid_ok;
        // lowest zero bit of the mask marks the even/odd selector position
        mask_x     = {1'b0, ent.mask};
        sel_onehot = ~mask_x & (mask_x + 1'b1);
        odd_sel    = |(pn & sel_onehot);
    end
endmodule

// File: rtl/tlbx_prio.sv
module tlbx_prio #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlbx.sv
module tlbx
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_req,
    input  logic [VA_W-1:0]     lk_vaddr,
    input  logic [ASID_W-1:0]   lk_asid,
    output logic                lk_done,
    output logic                lk_hit,
    output logic                lk_invalid,
    output logic [IDX_W:0]      lk_index,
    output logic [PFN_W-1:0]    lk_pfn,
    output logic [CATTR_W-1:0]  lk_cattr,
    output logic                lk_dirty,
    output logic                lk_uncached,
    input  logic                wr_en,
    input  logic [IDX_W:0]      wr_index,
    input  logic [VPN2_W-1:0]   wr_mask,
    input  logic [VPN2_W-1:0]   wr_vpn2,
    input  logic [ASID_W-1:0]   wr_asid,
    input  logic                wr_global,
    input  logic [HALF_W-1:0]   wr_even_word,
    input  logic [HALF_W-1:0]   wr_odd_word,
    input  logic                flush,
    input  logic                fill_adv,
    output logic [IDX_W-1:0]    fill_idx,
    input  logic [IDX_W-1:0]    rd_index,
    output logic [VPN2_W-1:0]   rd_mask,
    output logic [VA_W-1:0]     rd_vpn_word,
    output logic [HALF_W-1:0]   rd_even_word,
    output logic [HALF_W-1:0]   rd_odd_word
);
    localparam logic [IDX_W:0]   ENT_CNT  = (IDX_W+1)'(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        entry_t [ENTRIES-1:0] tab;
        logic [IDX_W-1:0]     fill;
        logic                 done;
        logic                 hit;
        logic                 inval;
        logic [IDX_W:0]       idx;
        half_t                sel;
        logic                 unc;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] odd_vec;
    logic               found;
    logic [IDX_W-1:0]   win;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        tlbx_match u_match (
            .ent     (s_q.tab[g]),
            .pn      (lk_vaddr[VA_W-1:PAGE_SHIFT]),
            .asid    (lk_asid),
            .match   (match_vec[g]),
            .odd_sel (odd_vec[g])
        );
    end

    tlbx_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
        .req   (match_vec),
        .found (found),
        .idx   (win)
    );

    always_comb begin
        half_t  pick;
        entry_t nw;
        s_d      = s_q;
        s_d.done = lk_req;
        pick     = '0;
        if (lk_req) begin
            s_d.hit   = 1'b0;
            s_d.inval = 1'b0;
            s_d.idx   = '1;
            s_d.sel   = '0;
            s_d.unc   = (lk_vaddr & UNCACHED_SEG) == UNCACHED_SEG;
            if (found) begin
                pick    = odd_vec[win] ? s_q.tab[win].odd : s_q.tab[win].even;
                s_d.idx = {1'b0, win};
                if (pick.valid) begin
                    s_d.hit = 1'b1;
                    s_d.sel = pick;
                end else begin
                    s_d.inval = 1'b1;
                end
            end
        end
        nw.mask     = wr_mask;
        nw.vpn2     = wr_vpn2;
        nw.asid     = wr_asid;
        nw.global_f = wr_global;
        nw.even     = half_t'(wr_even_word[HALF_W-1:1]);
        nw.odd      = half_t'(wr_odd_word[HALF_W-1:1]);
        if (wr_en && (wr_index < ENT_CNT)) begin
            s_d.tab[wr_index[IDX_W-1:0]] = nw;
        end
        if (fill_adv) begin
            s_d.fill = (s_q.fill == LAST_IDX) ? '0 : s_q.fill + 1'b1;
        end
        if (flush) begin
            s_d.tab  = '0;
            s_d.fill = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    entry_t rd_ent;

    always_comb begin
        rd_ent       = s_q.tab[rd_index];
        rd_mask      = rd_ent.mask;
        rd_vpn_word  = {rd_ent.vpn2, {GAP_W{1'b0}}, rd_ent.asid};
        rd_even_word = {rd_ent.even, rd_ent.global_f};
        rd_odd_word  = {rd_ent.odd, rd_ent.global_f};
    end

    assign lk_done     = s_q.done;
    assign lk_hit      = s_q.hit;
    assign lk_invalid  = s_q.inval;
    assign lk_index    = s_q.idx;
    assign lk_pfn      = s_q.sel.pfn;
    assign lk_cattr    = s_q.sel.cattr;
    assign lk_dirty    = s_q.sel.dirty;
    assign lk_uncached = s_q.unc;
    assign fill_idx    = s_q.fill;
endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic [31:0]      lk_vaddr,
    input logic             lk_done,
    input logic             lk_hit,
    input logic             lk_invalid,
    input logic [IDX_W:0]   lk_index,
    input logic             lk_uncached,
    input logic             flush,
    input logic             fill_adv,
    input logic [IDX_W-1:0] fill_idx
);
    logic [IDX_W-1:0] fill_next;
    always_comb fill_next = (fill_idx == IDX_W'(ENTRIES - 1)) ? '0 : fill_idx + 1'b1;

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_done);
    assert_no_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_done);
    assert_hit_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_invalid));
    assert_miss_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && !lk_hit && !lk_invalid) |-> (&lk_index));
    assert_hit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && (lk_hit || lk_invalid)) |-> (lk_index < (IDX_W+1)'(ENTRIES)));
    assert_seg_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (lk_uncached == ($past(lk_vaddr[31]) && $past(lk_vaddr[29]))));
    assert_flush_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill_idx == '0));
    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && $past(flush, 2)) |-> (!lk_hit && !lk_invalid));
    assert_fill_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_adv && !flush) |=> (fill_idx == $past(fill_next)));
    assert_fill_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_adv && !flush) |=> $stable(fill_idx));
endmodule

bind tlbx tlbx_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_req      (lk_req),
    .lk_vaddr    (lk_vaddr),
    .lk_done     (lk_done),
    .lk_hit      (lk_hit),
    .lk_invalid  (lk_invalid),
    .lk_index    (lk_index),
    .lk_uncached (lk_uncached),
    .flush       (flush),
    .fill_adv    (fill_adv),
    .fill_idx    (fill_idx)
);

// File: tb/tlbx_bench.sv
`timescale 1ns/1ps
module tlbx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_done, lk_hit, lk_invalid, lk_dirty, lk_uncached;
    logic [3:0]  lk_index;
    logic [19:0] lk_pfn;
    logic [2:0]  lk_cattr;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_index = '0;
    logic [18:0] wr_mask = '0, wr_vpn2 = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_global = 1'b0;
    logic [25:0] wr_even_word = '0, wr_odd_word = '0;
    logic        flush = 1'b0;
    logic        fill_adv = 1'b0;
    logic [2:0]  fill_idx;
    logic [2:0]  rd_index = '0;
    logic [18:0] rd_mask;
    logic [31:0] rd_vpn_word;
    logic [25:0] rd_even_word, rd_odd_word;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tlbx u_tlbx (.*);

    function automatic logic [25:0] hw(input logic [19:0] pfn, input logic [2:0] c,
                                       input logic d, input logic v);
        return {pfn, c, d, v, 1'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [18:0] m, input logic [18:0] v2,
                      input logic [7:0] a, input logic g, input logic [25:0] ev,
                      input logic [25:0] od);
        @(negedge clk);
        wr_en = 1; wr_index = idx; wr_mask = m; wr_vpn2 = v2; wr_asid = a;
        wr_global = g; wr_even_word = ev; wr_odd_word = od;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] a);
        @(negedge clk);
        lk_req = 1; lk_vaddr = va; lk_asid = a;
        @(negedge clk);
        lk_req = 0;
    endtask

    task automatic expect_hit(input string req, input logic [3:0] idx, input logic [19:0] pfn,
                              input logic [2:0] c, input logic d);
        chk(lk_done && lk_hit && !lk_invalid, req, {lk_done, lk_hit, lk_invalid}, 3'b110);
        chk(lk_index == idx, req, lk_index, idx);
        chk(lk_pfn == pfn && lk_cattr == c && lk_dirty == d, req,
            {lk_pfn, lk_cattr, lk_dirty}, {pfn, c, d});
    endtask

    task automatic expect_miss(input string req);
        chk(lk_done && !lk_hit && !lk_invalid && lk_index == 4'hF && lk_pfn == 0, req,
            {lk_done, lk_hit, lk_invalid, lk_index, lk_pfn}, {3'b100, 4'hF, 20'h0});
    endtask

    task automatic t_reset;
        chk(!lk_done && fill_idx == 0, "R7 reset", {lk_done, fill_idx}, 0);
        chk(rd_vpn_word == 0 && rd_even_word == 0, "R10 reset", rd_vpn_word, 0);
    endtask

    task automatic t_basic;
        wr(0, 0, 19'h12345, 8'h05, 0, hw(20'hABCDE, 3, 1, 1), hw(20'h11111, 2, 0, 1));
        look({19'h12345, 1'b0, 12'h123}, 8'h05);
        expect_hit("R1 R3 R7 even", 0, 20'hABCDE, 3, 1);
        look({19'h12345, 1'b1, 12'h000}, 8'h05);
        expect_hit("R3 odd", 0, 20'h11111, 2, 0);
        look({19'h12345, 1'b0, 12'h000}, 8'h06);
        expect_miss("R2 asid mismatch");
        look({19'h12344, 1'b0, 12'h000}, 8'h05);
        expect_miss("R1 tag mismatch");
    endtask

    task automatic t_global;
        wr(1, 0, 19'h00777, 8'h09, 1, hw(20'h0F0F0, 1, 0, 1), hw(20'h0, 0, 0, 0));
        look({19'h00777, 1'b0, 12'h000}, 8'h33);
        expect_hit("R2 global", 1, 20'h0F0F0, 1, 0);
    endtask

    task automatic t_mask;
        wr(2, 19'h0000F, 19'h20000, 8'h07, 0, hw(20'h22222, 4, 0, 1), hw(20'h33333, 5, 1, 1));
        look({19'h20005, 1'b1, 12'h000}, 8'h07);
        expect_hit("R1 R3 masked even", 2, 20'h22222, 4, 0);
        look({19'h2000A, 1'b0, 12'h000}, 8'h07);
        expect_hit("R1 R3 masked odd", 2, 20'h33333, 5, 1);
        look({19'h20010, 1'b0, 12'h000}, 8'h07);
        expect_miss("R1 above mask");
    endtask

    task automatic t_prio;
        wr(5, 0, 19'h44444, 8'h00, 1, hw(20'h55555, 0, 0, 1), hw(20'h55555, 0, 0, 1));
        wr(3, 0, 19'h44444, 8'h00, 1, hw(20'h33330, 0, 0, 1), hw(20'h33330, 0, 0, 1));
        look({19'h44444, 1'b0, 12'h000}, 8'h42);
        expect_hit("R4 lowest index", 3, 20'h33330, 0, 0);
    endtask

    task automatic t_invalid;
        wr(6, 0, 19'h55555, 8'h01, 0, hw(20'h66666, 1, 1, 1), hw(20'h77777, 1, 1, 0));
        look({19'h55555, 1'b1, 12'h000}, 8'h01);
        chk(lk_done && !lk_hit && lk_invalid && lk_index == 6 && lk_pfn == 0,
            "R6 invalid half", {lk_hit, lk_invalid, lk_index, lk_pfn}, {2'b01, 4'h6, 20'h0});
    endtask

    task automatic t_bad_write;
        wr(8, 0, 19'h66666, 8'h00, 1, hw(20'h1, 0, 0, 1), hw(20'h1, 0, 0, 1));
        wr(15, 0, 19'h66666, 8'h00, 1, hw(20'h1, 0, 0, 1), hw(20'h1, 0, 0, 1));
        look({19'h66666, 1'b0, 12'h000}, 8'h00);
        expect_miss("R8 out-of-range write");
        for (int i = 0; i < 8; i++) begin
            rd_index = 3'(i);
            #1;
            if (i == 7 || i == 4)
                chk(rd_vpn_word == 0, "R8 entries untouched", rd_vpn_word, 0);
        end
    endtask

    task automatic t_readback;
        rd_index = 0;
        #1;
        chk(rd_vpn_word == ((32'h12345 << 13) | 32'h05), "R9 pair word",
            rd_vpn_word, (32'h12345 << 13) | 32'h05);
        chk(rd_even_word == ((26'hABCDE << 6) | (3 << 3) | (1 << 2) | (1 << 1)),
            "R9 even word", rd_even_word, (26'hABCDE << 6) | 26'h1E);
        rd_index = 1;
        #1;
        chk(rd_even_word == ((26'h0F0F0 << 6) | (1 << 3) | (1 << 1) | 1),
            "R9 global bit", rd_even_word, (26'h0F0F0 << 6) | 26'hB);
        rd_index = 2;
        #1;
        chk(rd_mask == 19'h0000F, "R9 mask", rd_mask, 19'hF);
    endtask

    task automatic t_uncached;
        look(32'hA000_1000, 8'h0);
        chk(lk_uncached == 1, "R12 A-segment", lk_uncached, 1);
        look(32'h8000_1000, 8'h0);
        chk(lk_uncached == 0, "R12 bit29 clear", lk_uncached, 0);
        look(32'h2000_1000, 8'h0);
        chk(lk_uncached == 0, "R12 bit31 clear", lk_uncached, 0);
        look(32'hE000_0000, 8'h0);
        chk(lk_uncached == 1, "R12 E-segment", lk_uncached, 1);
    endtask

    task automatic adv(input int n);
        @(negedge clk);
        fill_adv = 1;
        repeat (n) @(negedge clk);
        fill_adv = 0;
    endtask

    task automatic t_fill;
        adv(3);
        chk(fill_idx == 3, "R11 advance", fill_idx, 3);
        repeat (2) @(negedge clk);
        chk(fill_idx == 3, "R11 hold", fill_idx, 3);
        adv(5);
        chk(fill_idx == 0, "R11 wrap", fill_idx, 0);
        adv(2);
        chk(fill_idx == 2, "R11 after wrap", fill_idx, 2);
    endtask

    task automatic t_flush;
        @(negedge clk);
        flush = 1; fill_adv = 1;
        wr_en = 1; wr_index = 7; wr_mask = 0; wr_vpn2 = 19'h12345; wr_asid = 8'h05;
        wr_global = 1; wr_even_word = hw(20'h1, 0, 0, 1); wr_odd_word = 0;
        @(negedge clk);
        flush = 0; fill_adv = 0; wr_en = 0;
        chk(fill_idx == 0, "R10 pointer cleared", fill_idx, 0);
        look({19'h12345, 1'b0, 12'h000}, 8'h05);
        expect_miss("R10 flushed lookup");
        rd_index = 7;
        #1;
        chk(rd_vpn_word == 0 && rd_even_word == 0, "R10 flush beats write", rd_vpn_word, 0);
        rd_index = 0;
        #1;
        chk(rd_vpn_word == 0, "R10 entry zeroed", rd_vpn_word, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_global;
        t_mask;
        t_prio;
        t_invalid;
        t_bad_write;
        t_readback;
        t_uncached;
        t_fill;
        t_flush;
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule